// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Controller

This block turns one pulse-width command into two gate-enable outputs for a synchronous half bridge. One output is for the upper switch and one is for the lower switch. Instead of a fixed blanking delay, the block waits until the opposite switch's gate is reported discharged. Each switch has a sense flag that goes high once its gate-to-source voltage has dropped below about one volt. A programmable floor of idle cycles is always inserted, so a very fast sense path cannot shrink the gap to nothing. A timeout catches a sense flag that never arrives.

A supervisor can act on the bridge in two ways. It can force both switches off. It can also force the lower switch on as an over-voltage crowbar, and this ignores the pulse command. Pulses shorter than a minimum on-time never reach the upper gate. A stuck sense flag latches a shoot-through error and leaves both switches off until the block is disabled.

Top module: `dtg_deadtime_ctrl`

## Requirements
- R1: In reset and on the first cycle after reset, both drive outputs and the error flag are 0.
- R2: The low-side drive rises only in a cycle after one where the high-side gate-low flag was sampled 1. When the flag comes in late, the off gap is exactly the flag delay.
- R3: The high-side drive rises only in a cycle after one where the low-side gate-low flag was sampled 1. When the flag comes in late, the off gap is exactly the flag delay.
- R4: Between one drive falling and the other rising, both drives are off for at least DT_MIN cycles, even when the awaited flag is already 1. With an immediate flag the gap is exactly DT_MIN.
- R5: The pulse command counts only after it has been sampled high on MIN_ON consecutive clocks. A shorter high pulse never raises the high-side drive.
- R6: While force_ls is 1, the high-side drive is 0 from the next cycle on. The low-side drive turns on through the normal flag wait and stays on whatever pwm_cmd does.
- R7: When en is 0 or force_off is 1, both drives are 0 on the next cycle.
- R8: If the awaited flag is still 0 after TMO cycles of waiting, the block enters a fault state. In that state both drives are 0 and shoot_err is 1, whatever pwm_cmd or the overrides do, for as long as en stays 1.
- R9: The two drive outputs are never 1 in the same cycle. Such a cycle would also raise shoot_err.
- R10: Setting en to 0 clears shoot_err on the next cycle. After en returns to 1 the bridge starts up again from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low clears a fault |
| pwm_cmd | input | 1 | Pulse command, 1 = upper switch wanted |
| force_off | input | 1 | Supervisor override: both switches off |
| force_ls | input | 1 | Supervisor crowbar: lower switch on, upper off |
| hs_gate_low | input | 1 | Upper gate discharged below about 1 V |
| ls_gate_low | input | 1 | Lower gate discharged below about 1 V |
| hs_drive | output | 1 | Upper switch gate enable |
| ls_drive | output | 1 | Lower switch gate enable |
| shoot_err | output | 1 | Shoot-through / stuck-sense error |

## Verification
The bench runs gate-sense flags that follow the drive outputs with a chosen delay. A zero delay shows the fixed floor at work. A long delay shows that the adaptive wait, and not the floor, sets the gap. Pulse trains near the minimum on-time, one cycle under it and well above it, tell pulse suppression apart from normal switching. A flag held stuck low separates the timeout-and-latch path from an ordinary slow gate. Crowbar and force-off bursts applied in the middle of a pulse show that the overrides take priority over the command.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_WAIT = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_LS_WAIT = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_FAULT   = 3'd5
    } dtg_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // True for the two states where the bridge is dark and waiting on a flag.
    function automatic logic is_wait(input dtg_state_e s);
        return (s == ST_HS_WAIT) || (s == ST_LS_WAIT);
    endfunction

    // Drive enables implied by a state.
    function automatic gate_pair_t gates_of(input dtg_state_e s);
        gate_pair_t g;
        g.hs = (s == ST_HS_ON);
        g.ls = (s == ST_LS_ON);
        return g;
    endfunction

endpackage

// File: rtl/dtg_pulse_qual.sv
module dtg_pulse_qual #(
    parameter int MIN_ON = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_cmd,
    output logic cmd_q
);
    generate
        if (MIN_ON == 0) begin : g_bypass
            always_ff @(posedge clk) begin
                if (rst) cmd_q <= 1'b0;
                else     cmd_q <= pwm_cmd;
            end
        end else begin : g_filter
            localparam int RW = $clog2(MIN_ON + 2);
            localparam logic [RW-1:0] LIM = RW'(MIN_ON);
            logic [RW-1:0] run_q;
            logic [RW-1:0] run_nx;

            always_comb begin
                if (!pwm_cmd)          run_nx = '0;
                else if (run_q == LIM) run_nx = run_q;
                else                   run_nx = run_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q <= '0;
                    cmd_q <= 1'b0;
                end else begin
                    run_q <= run_nx;
                    cmd_q <= (run_nx == LIM);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dtg_wait_timer.sv
module dtg_wait_timer #(
    parameter int DT_MIN = 4,
    parameter int TMO    = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic floor_met,
    output logic expired
);
    localparam int CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] TOP   = CW'(TMO);
    localparam logic [CW-1:0] FLOOR = CW'((DT_MIN > 0) ? DT_MIN - 1 : 0);
    localparam logic [CW-1:0] LAST  = CW'(TMO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt_q <= '0;
        else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign floor_met = (cnt_q >= FLOOR);
    assign expired   = (cnt_q == LAST);
endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       force_off,
    input  logic       force_ls,
    input  logic       cmd_q,
    input  logic       hs_gate_low,
    input  logic       ls_gate_low,
    input  logic       floor_met,
    input  logic       expired,
    output dtg_state_e state,
    output logic       tmr_clr
);
    dtg_state_e nxt;
    logic want_hs;

    assign want_hs = cmd_q && !force_ls;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else if (state == ST_FAULT) begin
            nxt = ST_FAULT;
        end else if (force_off) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = want_hs ? ST_HS_WAIT : ST_LS_WAIT;
                ST_HS_ON:   if (!want_hs) nxt = ST_LS_WAIT;
                ST_LS_ON:   if (want_hs)  nxt = ST_HS_WAIT;
                ST_HS_WAIT: begin
                    if (!want_hs)                      nxt = ST_LS_WAIT;
                    else if (ls_gate_low && floor_met) nxt = ST_HS_ON;
                    else if (expired)                  nxt = ST_FAULT;
                end
                ST_LS_WAIT: begin
                    if (want_hs)                       nxt = ST_HS_WAIT;
                    else if (hs_gate_low && floor_met) nxt = ST_LS_ON;
                    else if (expired)                  nxt = ST_FAULT;
                end
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // The wait counter restarts whenever the state changes.
    assign tmr_clr = (nxt != state) || !is_wait(state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/dtg_out_dec.sv
module dtg_out_dec
    import dtg_pkg::*;
(
    input  dtg_state_e state,
    output logic       hs_drive,
    output logic       ls_drive,
    output logic       shoot_err
);
    gate_pair_t g;

    always_comb begin
        g         = gates_of(state);
        hs_drive  = g.hs;
        ls_drive  = g.ls;
        shoot_err = (state == ST_FAULT) || (g.hs && g.ls);
    end
endmodule

// File: rtl/dtg_deadtime_ctrl.sv
module dtg_deadtime_ctrl
    import dtg_pkg::*;
#(
    parameter int DT_MIN = 4,
    parameter int TMO    = 64,
    parameter int MIN_ON = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pwm_cmd,
    input  logic force_off,
    input  logic force_ls,
    input  logic hs_gate_low,
    input  logic ls_gate_low,
    output logic hs_drive,
    output logic ls_drive,
    output logic shoot_err
);
    logic       cmd_q;
    logic       tmr_clr;
    logic       floor_met;
    logic       expired;
    dtg_state_e state;

    dtg_pulse_qual #(.MIN_ON(MIN_ON)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .pwm_cmd (pwm_cmd),
        .cmd_q   (cmd_q)
    );

    dtg_wait_timer #(.DT_MIN(DT_MIN), .TMO(TMO)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr       (tmr_clr),
        .floor_met (floor_met),
        .expired   (expired)
    );

    dtg_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .force_off   (force_off),
        .force_ls    (force_ls),
        .cmd_q       (cmd_q),
        .hs_gate_low (hs_gate_low),
        .ls_gate_low (ls_gate_low),
        .floor_met   (floor_met),
        .expired     (expired),
        .state       (state),
        .tmr_clr     (tmr_clr)
    );

    dtg_out_dec u_dec (
        .state     (state),
        .hs_drive  (hs_drive),
        .ls_drive  (ls_drive),
        .shoot_err (shoot_err)
    );
endmodule

// File: rtl/dtg_deadtime_ctrl_chk.sv
module dtg_deadtime_ctrl_chk #(
    parameter int DT_MIN = 4,
    parameter int TMO    = 64,
    parameter int MIN_ON = 40
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic pwm_cmd,
    input logic force_off,
    input logic force_ls,
    input logic hs_gate_low,
    input logic ls_gate_low,
    input logic hs_drive,
    input logic ls_drive,
    input logic shoot_err
);
    int unsigned off_run;
    int unsigned cmd_run;
    logic        hs_prev;
    logic        ls_prev;

    // R4 floor and R5 on-time windows are tracked with counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            off_run <= 0;
            cmd_run <= 0;
            hs_prev <= 1'b0;
            ls_prev <= 1'b0;
        end else begin
            if (hs_drive && !hs_prev)
                a_r4_floor_hs: assert (off_run >= DT_MIN);
            if (ls_drive && !ls_prev)
                a_r4_floor_ls: assert (off_run >= DT_MIN);
            if (hs_drive && !hs_prev)
                a_r5_min_on: assert (cmd_run >= MIN_ON);
            off_run <= (!hs_drive && !ls_drive) ? ((off_run < DT_MIN) ? off_run + 1 : off_run) : 0;
            cmd_run <= pwm_cmd ? ((cmd_run < MIN_ON) ? cmd_run + 1 : cmd_run) : 0;
            hs_prev <= hs_drive;
            ls_prev <= ls_drive;
        end
    end

    a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
        !(hs_drive && ls_drive));

    a_r2_ls_after_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_drive) |-> $past(hs_gate_low));

    a_r3_hs_after_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_drive) |-> $past(ls_gate_low));

    a_r7_forced_dark: assert property (@(posedge clk) disable iff (rst)
        (!en || force_off) |=> (!hs_drive && !ls_drive));

    a_r6_crowbar_hs_off: assert property (@(posedge clk) disable iff (rst)
        force_ls |=> !hs_drive);

    a_r8_err_latched: assert property (@(posedge clk) disable iff (rst)
        (shoot_err && en) |=> shoot_err);

    a_r8_err_dark: assert property (@(posedge clk) disable iff (rst)
        shoot_err |-> (!hs_drive && !ls_drive));

    a_r10_err_cleared: assert property (@(posedge clk) disable iff (rst)
        !en |=> !shoot_err);

endmodule

bind dtg_deadtime_ctrl dtg_deadtime_ctrl_chk #(
    .DT_MIN (DT_MIN),
    .TMO    (TMO),
    .MIN_ON (MIN_ON)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .pwm_cmd     (pwm_cmd),
    .force_off   (force_off),
    .force_ls    (force_ls),
    .hs_gate_low (hs_gate_low),
    .ls_gate_low (ls_gate_low),
    .hs_drive    (hs_drive),
    .ls_drive    (ls_drive),
    .shoot_err   (shoot_err)
);

// File: tb/dtg_deadtime_ctrl_bench.sv
module dtg_deadtime_ctrl_bench;
    localparam int DT_MIN = 4;
    localparam int TMO    = 64;
    localparam int MIN_ON = 40;
    localparam int WD_CYC = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, pwm_cmd = 1'b0, force_off = 1'b0, force_ls = 1'b0;
    logic hs_gate_low = 1'b1, ls_gate_low = 1'b1;
    logic hs_drive, ls_drive, shoot_err;

    always #2.5 clk = ~clk;

    dtg_deadtime_ctrl #(.DT_MIN(DT_MIN), .TMO(TMO), .MIN_ON(MIN_ON)) u_dtg_deadtime_ctrl (
        .clk(clk), .rst(rst), .en(en), .pwm_cmd(pwm_cmd),
        .force_off(force_off), .force_ls(force_ls),
        .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low),
        .hs_drive(hs_drive), .ls_drive(ls_drive), .shoot_err(shoot_err)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- gate-sense emulation ----------------
    int lag_hs = 2, lag_ls = 2;
    bit stuck_hs = 0, stuck_ls = 0;
    int hs_off_cnt = 0, ls_off_cnt = 0;

    // ---------------- behavioural reference ----------------
    bit m_hs, m_ls, m_fault, m_waiting, m_side_hs, m_qual;
    int m_wcnt, m_run;

    always @(posedge clk) begin
        bit prev_qual, want;
        prev_qual = m_qual;
        if (rst) begin
            m_hs = 0; m_ls = 0; m_fault = 0; m_waiting = 0; m_side_hs = 0;
            m_wcnt = 0; m_run = 0; m_qual = 0;
        end else begin
            m_run  = pwm_cmd ? ((m_run < MIN_ON) ? m_run + 1 : m_run) : 0;
            m_qual = (m_run == MIN_ON);
            want   = prev_qual && !force_ls;
            if (!en) begin
                m_hs = 0; m_ls = 0; m_fault = 0; m_waiting = 0;
            end else if (m_fault) begin
                // latched dark
            end else if (force_off) begin
                m_hs = 0; m_ls = 0; m_waiting = 0;
            end else if (m_hs) begin
                if (!want) begin m_hs = 0; m_waiting = 1; m_side_hs = 0; m_wcnt = 0; end
            end else if (m_ls) begin
                if (want) begin m_ls = 0; m_waiting = 1; m_side_hs = 1; m_wcnt = 0; end
            end else if (!m_waiting) begin
                m_waiting = 1; m_side_hs = want; m_wcnt = 0;
            end else if (want != m_side_hs) begin
                m_side_hs = want; m_wcnt = 0;
            end else if ((m_side_hs ? ls_gate_low : hs_gate_low) && m_wcnt >= DT_MIN - 1) begin
                m_waiting = 0;
                if (m_side_hs) m_hs = 1; else m_ls = 1;
            end else if (m_wcnt == TMO - 1) begin
                m_waiting = 0; m_fault = 1;
            end else begin
                m_wcnt++;
            end
        end
    end

    // ---------------- per-cycle comparison and flag update ----------------
    int gap_run = 0, last_gap = -1, hs_rises = 0;
    bit hs_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(hs_drive === m_hs, cur_req, "hs_drive vs model", hs_drive, m_hs);
            check(ls_drive === m_ls, cur_req, "ls_drive vs model", ls_drive, m_ls);
            check(shoot_err === m_fault, cur_req, "shoot_err vs model", shoot_err, m_fault);
            check(!(hs_drive && ls_drive), "R9", "both drives high", 1, 0);
            if (hs_drive && !hs_seen) begin
                last_gap = gap_run; hs_rises++;
            end
            gap_run = (!hs_drive && !ls_drive) ? gap_run + 1 : 0;
            hs_seen = hs_drive;
        end
        hs_off_cnt = hs_drive ? 0 : hs_off_cnt + 1;
        ls_off_cnt = ls_drive ? 0 : ls_off_cnt + 1;
        hs_gate_low = !stuck_hs && (hs_off_cnt > lag_hs);
        ls_gate_low = !stuck_ls && (ls_off_cnt > lag_ls);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_CYC && !done) begin
            check(0, "WD", "watchdog expired", cyc, WD_CYC);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int rises0;
        tick(4);
        check(hs_drive == 0 && ls_drive == 0 && shoot_err == 0, "R1", "outputs in reset",
              {hs_drive, ls_drive, shoot_err}, 0);
        rst = 0;
        tick(1);
        check(hs_drive == 0 && ls_drive == 0 && shoot_err == 0, "R1", "outputs after reset",
              {hs_drive, ls_drive, shoot_err}, 0);

        // R2: start dark, command low -> lower switch after flag
        cur_req = "R2";
        en = 1; lag_hs = 3; lag_ls = 10;
        tick(20);
        check(ls_drive == 1, "R2", "ls on with command low", ls_drive, 1);

        // R3: slow lower gate sets the gap
        cur_req = "R3";
        pwm_cmd = 1;
        tick(80);
        check(hs_drive == 1, "R3", "hs on after wait", hs_drive, 1);
        check(last_gap == lag_ls + 1, "R3", "gap follows late flag", last_gap, lag_ls + 1);

        // R4: instant flag, floor sets the gap
        cur_req = "R4";
        lag_ls = 0;
        pwm_cmd = 0; tick(30);
        pwm_cmd = 1; tick(70);
        check(last_gap == DT_MIN, "R4", "gap equals floor", last_gap, DT_MIN);

        // R2/R3: pulse train under the model
        cur_req = "R2";
        lag_hs = 2; lag_ls = 2;
        for (int i = 0; i < 5; i++) begin
            pwm_cmd = 1; tick(60);
            pwm_cmd = 0; tick(40);
        end
        check(ls_drive == 1, "R2", "ls on after train", ls_drive, 1);

        // R5: short pulses are swallowed
        cur_req = "R5";
        rises0 = hs_rises;
        pwm_cmd = 1; tick(MIN_ON - 1); pwm_cmd = 0; tick(20);
        pwm_cmd = 1; tick(MIN_ON);     pwm_cmd = 0; tick(20);
        check(hs_rises == rises0, "R5", "hs rises for short pulses", hs_rises - rises0, 0);
        pwm_cmd = 1; tick(MIN_ON + 20); pwm_cmd = 0; tick(20);
        check(hs_rises == rises0 + 1, "R5", "hs rises for long pulse", hs_rises - rises0, 1);

        // R6: crowbar in mid pulse
        cur_req = "R6";
        pwm_cmd = 1; tick(70);
        force_ls = 1; tick(1);
        check(hs_drive == 0, "R6", "hs off under crowbar", hs_drive, 0);
        tick(20);
        check(ls_drive == 1, "R6", "ls on under crowbar", ls_drive, 1);
        for (int i = 0; i < 3; i++) begin
            pwm_cmd = ~pwm_cmd; tick(50);
        end
        check(ls_drive == 1 && hs_drive == 0, "R6", "crowbar held", {hs_drive, ls_drive}, 1);
        force_ls = 0;

        // R7: force-off and disable
        cur_req = "R7";
        pwm_cmd = 1; tick(80);
        force_off = 1; tick(1);
        check(hs_drive == 0 && ls_drive == 0, "R7", "dark after force_off", {hs_drive, ls_drive}, 0);
        tick(10);
        check(hs_drive == 0 && ls_drive == 0, "R7", "dark held", {hs_drive, ls_drive}, 0);
        force_off = 0; tick(80);
        check(hs_drive == 1, "R7", "hs back after release", hs_drive, 1);
        en = 0; tick(1);
        check(hs_drive == 0 && ls_drive == 0, "R7", "dark after disable", {hs_drive, ls_drive}, 0);

        // R8: stuck upper flag -> timeout fault
        cur_req = "R8";
        en = 1; pwm_cmd = 1; tick(90);
        stuck_hs = 1; pwm_cmd = 0;
        tick(TMO + 10);
        check(shoot_err == 1, "R8", "error after timeout", shoot_err, 1);
        check(hs_drive == 0 && ls_drive == 0, "R8", "dark in fault", {hs_drive, ls_drive}, 0);
        stuck_hs = 0;
        for (int i = 0; i < 2; i++) begin
            pwm_cmd = ~pwm_cmd; tick(60);
        end
        force_ls = 1; tick(20); force_ls = 0;
        check(shoot_err == 1 && hs_drive == 0 && ls_drive == 0, "R8", "fault latched",
              {shoot_err, hs_drive, ls_drive}, 4);

        // R10: disable clears the latch
        cur_req = "R10";
        en = 0; tick(1);
        check(shoot_err == 0, "R10", "error cleared", shoot_err, 0);
        pwm_cmd = 0; en = 1; tick(30);
        check(ls_drive == 1, "R10", "restart to ls", ls_drive, 1);

        // R8: stuck lower flag while waiting for the upper switch
        cur_req = "R8";
        stuck_ls = 1; pwm_cmd = 1; tick(MIN_ON + TMO + 20);
        check(shoot_err == 1 && hs_drive == 0, "R8", "upper wait timeout", {shoot_err, hs_drive}, 2);
        stuck_ls = 0; en = 0; tick(2);

        finish_run();
    end
endmodule